// File: doc/BRIEF.md
# Cache Flush Sequencer

This block runs a whole-cache flush for a write-back cache. A rising edge on the flush request starts the flush. The sequencer walks the lines in ascending index order. It writes back every modified line through a request/grant bus handshake that lasts a fixed number of cycles, and then it invalidates the whole table in one cycle. Last, it issues a one-cycle flush-acknowledge special cycle. The cache contents are modelled by a small table of valid and dirty bits. A fill port loads the table and a probe port reads it back.

Another agent can take the bus away through backoff, address-hold or hold-acknowledge. The flush then suspends and picks up again when the bus returns. A writeback that is cut off is run again from its first cycle. A flush requested during the stop-grant low-power state waits until that state ends. Edge-triggered interrupt requests that arrive during a flush are held. After the acknowledge they are presented one per cycle in a fixed priority order. If the flush request is high while reset is active, the block enters a float-test mode. In that mode the bus output enable is low and all activity stops until the next reset.

Top module: `cflush_seq`

## Requirements
- R1: A flush starts only on a 0-to-1 transition of `flush_req`. Holding the input high produces exactly one flush.
- R2: Each valid line whose dirty bit is set gets exactly one writeback. Writebacks run in ascending line order, and `wb_line` names the line while `bus_req` is high. When the flush ends, every line reads back invalid and clean.
- R3: With the bus free, `flush_ack` is high for exactly one cycle. It comes after all writebacks and the invalidation. `flush_busy` is high for LINES + D*(WB_CYCLES+1) + 3 cycles, where D is the number of dirty lines.
- R4: Backoff during a writeback transfer aborts that writeback. Once the bus is free again, the same line is written back from the start. Lines already written back are not repeated.
- R5: If the bus is held and no line is dirty, all lines are invalidated while the bus is still held. `flush_ack` waits until the bus is released.
- R6: If the bus is held and a line is dirty, the flush stops at that line with `bus_req` low and no line invalidated. After the bus is released the full flush completes.
- R7: A flush edge seen while `stop_grant` is high does not start a flush until `stop_grant` falls.
- R8: Interrupt edges (NMI, INIT, SMI, FLUSH) that arrive during a flush are latched. `irq_valid` is never high while `flush_busy` is high.
- R9: After the acknowledge, the latched requests are presented one per cycle in priority order. The `irq_id` codes are NMI=0, INIT=1, SMI=2 and FLUSH=3. A presented FLUSH starts a new flush.
- R10: If `flush_req` is high during reset, `float_test` goes high and `bus_oe` goes low. The block then ignores all requests until the next reset taken with `flush_req` low.
- R11: After a reset with `flush_req` low, all lines are invalid, `flush_busy`, `bus_req` and `float_test` are low, and `bus_oe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_req | input | 1 | Flush request, edge-detected |
| smi_req | input | 1 | System-management interrupt request, edge-detected |
| init_req | input | 1 | Init request, edge-detected |
| nmi_req | input | 1 | Non-maskable interrupt request, edge-detected |
| stop_grant | input | 1 | High while in the low-power stop-grant state |
| bus_boff | input | 1 | Backoff: bus taken away immediately |
| bus_ahold | input | 1 | Address hold by another agent |
| bus_hlda | input | 1 | Hold acknowledged to another master |
| bus_gnt | input | 1 | Grant for a writeback request |
| fill_en | input | 1 | Load one table line (ignored during a flush) |
| fill_idx | input | IW | Line to load |
| fill_dirty | input | 1 | Dirty bit for the loaded line |
| probe_idx | input | IW | Line to read back |
| bus_req | output | 1 | Writeback bus request, high through the transfer |
| wb_line | output | IW | Line being written back |
| flush_ack | output | 1 | One-cycle flush-acknowledge special cycle |
| flush_busy | output | 1 | Flush in progress |
| irq_valid | output | 1 | A latched interrupt is presented this cycle |
| irq_id | output | 2 | Code of the presented interrupt |
| probe_valid | output | 1 | Valid bit of the probed line |
| probe_dirty | output | 1 | Dirty bit of the probed line |
| bus_oe | output | 1 | Bus output enable, low in float-test mode |
| float_test | output | 1 | Float-test mode active |

## Verification
The bench builds the block with 8 lines and a 3-cycle writeback transfer. This makes it possible to sweep all 256 dirty patterns. For each pattern the bench checks the writeback count, the order of lines, and the exact busy length against the formula in R3. At this size each flush lasts only tens of cycles, so the directed cases also fit easily in the run. These cases cover backoff in mid-transfer, the two held-bus outcomes, stop-grant deferral, the interrupt priority replay and float-test entry and exit.

// File: rtl/cfs_pkg.sv
// Shared types for the cache flush sequencer.
// Assumes: four edge-triggered interrupt sources, lowest code wins.
package cfs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_WB_REQ,
        ST_WB_XFER,
        ST_INVAL,
        ST_ACK_WAIT,
        ST_ACK
    } fl_state_t;

    localparam int IRQ_N = 4;
    localparam logic [1:0] IRQ_NMI   = 2'd0;
    localparam logic [1:0] IRQ_INIT  = 2'd1;
    localparam logic [1:0] IRQ_SMI   = 2'd2;
    localparam logic [1:0] IRQ_FLUSH = 2'd3;
endpackage

// File: rtl/cfs_line_table.sv
// Valid/dirty table standing in for the cache tag array.
// A fill loads one line, a completed writeback clears one dirty bit,
// and invalidate-all clears every line in one cycle.
// Assumes: the caller blocks fills during a flush.
module cfs_line_table #(
    parameter int LINES = 16,
    localparam int IW = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_en,
    input  logic [IW-1:0]    fill_idx,
    input  logic             fill_dirty,
    input  logic             clr_en,
    input  logic [IW-1:0]    clr_idx,
    input  logic             inval_all,
    input  logic [IW-1:0]    probe_idx,
    output logic [LINES-1:0] valid_vec,
    output logic [LINES-1:0] dirty_vec,
    output logic             probe_valid,
    output logic             probe_dirty
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        // Per-line state update.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_vec[g] <= 1'b0;
                dirty_vec[g] <= 1'b0;
            end else if (inval_all) begin
                valid_vec[g] <= 1'b0;
                dirty_vec[g] <= 1'b0;
            end else if (fill_en && fill_idx == IW'(g)) begin
                valid_vec[g] <= 1'b1;
                dirty_vec[g] <= fill_dirty;
            end else if (clr_en && clr_idx == IW'(g)) begin
                dirty_vec[g] <= 1'b0;
            end
        end
    end

    // Read-back port.
    always_comb begin
        probe_valid = valid_vec[probe_idx];
        probe_dirty = dirty_vec[probe_idx];
    end

    assert_dirty_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty_vec & ~valid_vec) == '0);
endmodule

// File: rtl/cfs_irq_latch.sv
// Edge detection, flush start gating and deferred interrupt replay.
// Edges seen during a flush are kept in a pending mask. With no flush
// running, one pending request is presented per cycle, lowest code first.
// Assumes: busy comes from the flush controller; en is low in float-test.
module cfs_irq_latch
    import cfs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [IRQ_N-1:0] req,
    input  logic             busy,
    input  logic             stop_grant,
    output logic             start,
    output logic             irq_valid,
    output logic [1:0]       irq_id
);
    logic [IRQ_N-1:0] prev_q, pend_q, edges, clr_mask, new_pend;
    logic             hold_q, set_hold, dispatch;

    // Edge detect and pick of the highest-priority pending request.
    always_comb begin
        edges = req & ~prev_q;
        irq_id = '0;
        for (int i = IRQ_N - 1; i >= 0; i--) begin
            if (pend_q[i]) irq_id = 2'(i);
        end
        dispatch  = en && !busy && (pend_q != '0);
        irq_valid = dispatch;
        clr_mask  = dispatch ? (IRQ_N'(1) << irq_id) : '0;
        new_pend  = busy ? edges : (edges & ~(IRQ_N'(1) << IRQ_FLUSH));
        start     = en && hold_q && !busy && !stop_grant;
        set_hold  = (edges[IRQ_FLUSH] && !busy) || (dispatch && irq_id == IRQ_FLUSH);
    end

    // Previous input levels; a level held through reset is no edge.
    always_ff @(posedge clk) begin
        prev_q <= req;
    end

    // Pending mask and flush-hold bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            hold_q <= 1'b0;
        end else if (en) begin
            pend_q <= (pend_q & ~clr_mask) | new_pend;
            hold_q <= start ? 1'b0 : (hold_q | set_hold);
        end
    end

    assert_no_irq_in_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> !busy);
    assert_stopgrant_defers_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_grant && !busy) |=> !busy);
endmodule

// File: rtl/cfs_flush_ctrl.sv
// Flush sequencer. It scans the lines in order and writes back dirty ones
// through a request/grant handshake of WB_CYCLES transfer cycles. It then
// invalidates all lines and issues the acknowledge once the bus is free.
// Assumes: held is the OR of backoff, address-hold and hold-acknowledge.
module cfs_flush_ctrl
    import cfs_pkg::*;
#(
    parameter int LINES = 16,
    parameter int WB_CYCLES = 4,
    localparam int IW = $clog2(LINES),
    localparam int CW = (WB_CYCLES > 1) ? $clog2(WB_CYCLES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             start,
    input  logic             held,
    input  logic             bus_gnt,
    input  logic [LINES-1:0] valid_vec,
    input  logic [LINES-1:0] dirty_vec,
    output logic             bus_req,
    output logic [IW-1:0]    wb_line,
    output logic             clr_en,
    output logic [IW-1:0]    clr_idx,
    output logic             inval_all,
    output logic             flush_ack,
    output logic             busy
);
    fl_state_t     st;
    logic [IW-1:0] idx;
    logic [CW-1:0] cnt;
    logic          last, xfer_end;

    // Output decode from the current state.
    always_comb begin
        last      = (idx == IW'(LINES - 1));
        xfer_end  = (cnt == CW'(WB_CYCLES - 1));
        bus_req   = en && (st == ST_WB_REQ || st == ST_WB_XFER) && !held;
        wb_line   = idx;
        clr_en    = en && st == ST_WB_XFER && !held && xfer_end;
        clr_idx   = idx;
        inval_all = en && st == ST_INVAL;
        flush_ack = en && st == ST_ACK;
        busy      = st != ST_IDLE;
    end

    // State, line index and transfer counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            idx <= '0;
            cnt <= '0;
        end else if (en) begin
            case (st)
                ST_IDLE: if (start) begin
                    st  <= ST_SCAN;
                    idx <= '0;
                end
                ST_SCAN: begin
                    if (dirty_vec[idx]) st <= ST_WB_REQ;
                    else if (last)      st <= ST_INVAL;
                    else                idx <= idx + 1'b1;
                end
                ST_WB_REQ: if (!held && bus_gnt) begin
                    st  <= ST_WB_XFER;
                    cnt <= '0;
                end
                ST_WB_XFER: begin
                    if (held) begin
                        st <= ST_WB_REQ;
                    end else if (xfer_end) begin
                        if (last) begin
                            st <= ST_INVAL;
                        end else begin
                            idx <= idx + 1'b1;
                            st  <= ST_SCAN;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_INVAL:    st <= ST_ACK_WAIT;
                ST_ACK_WAIT: if (!held) st <= ST_ACK;
                ST_ACK:      st <= ST_IDLE;
                default:     st <= ST_IDLE;
            endcase
        end
    end

    assert_wb_only_dirty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> dirty_vec[clr_idx]);
    assert_no_inval_with_dirty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        inval_all |-> (dirty_vec == '0));
    assert_ack_after_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flush_ack |-> (valid_vec == '0 && dirty_vec == '0));
endmodule

// File: rtl/cflush_seq.sv
// Top of the cache flush sequencer. Latches float-test mode during reset,
// merges the bus-takeaway inputs, and wires the table, the controller and
// the interrupt latch together. In float-test mode all outputs are quiet.
// Assumes: synchronous active-low reset; inputs are synchronous to clk.
module cflush_seq
    import cfs_pkg::*;
#(
    parameter int LINES = 16,
    parameter int WB_CYCLES = 4,
    localparam int IW = $clog2(LINES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_req,
    input  logic          smi_req,
    input  logic          init_req,
    input  logic          nmi_req,
    input  logic          stop_grant,
    input  logic          bus_boff,
    input  logic          bus_ahold,
    input  logic          bus_hlda,
    input  logic          bus_gnt,
    input  logic          fill_en,
    input  logic [IW-1:0] fill_idx,
    input  logic          fill_dirty,
    input  logic [IW-1:0] probe_idx,
    output logic          bus_req,
    output logic [IW-1:0] wb_line,
    output logic          flush_ack,
    output logic          flush_busy,
    output logic          irq_valid,
    output logic [1:0]    irq_id,
    output logic          probe_valid,
    output logic          probe_dirty,
    output logic          bus_oe,
    output logic          float_test
);
    logic             float_q, en, held, busy, start, fill_ok;
    logic             clr_en, inval_all, req_i, ack_i, irqv_i, pv_i, pd_i;
    logic [IW-1:0]    clr_idx, line_i;
    logic [1:0]       id_i;
    logic [LINES-1:0] valid_vec, dirty_vec;
    logic [IRQ_N-1:0] req_vec;

    // Float-test flag: sampled during reset, kept until the next reset.
    always_ff @(posedge clk) begin
        if (!rst_n) float_q <= flush_req;
    end

    // Glue: bus ownership, request vector and float gating.
    always_comb begin
        en      = !float_q;
        held    = bus_boff || bus_ahold || bus_hlda;
        fill_ok = fill_en && !busy && en;
        req_vec = '0;
        req_vec[IRQ_NMI]   = nmi_req;
        req_vec[IRQ_INIT]  = init_req;
        req_vec[IRQ_SMI]   = smi_req;
        req_vec[IRQ_FLUSH] = flush_req;
        bus_req     = req_i && en;
        wb_line     = en ? line_i : '0;
        flush_ack   = ack_i && en;
        flush_busy  = busy && en;
        irq_valid   = irqv_i && en;
        irq_id      = en ? id_i : '0;
        probe_valid = pv_i && en;
        probe_dirty = pd_i && en;
        bus_oe      = en;
        float_test  = float_q;
    end

    cfs_line_table #(.LINES(LINES)) u_table (
        .clk(clk), .rst_n(rst_n),
        .fill_en(fill_ok), .fill_idx(fill_idx), .fill_dirty(fill_dirty),
        .clr_en(clr_en), .clr_idx(clr_idx), .inval_all(inval_all),
        .probe_idx(probe_idx),
        .valid_vec(valid_vec), .dirty_vec(dirty_vec),
        .probe_valid(pv_i), .probe_dirty(pd_i)
    );

    cfs_flush_ctrl #(.LINES(LINES), .WB_CYCLES(WB_CYCLES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .start(start), .held(held),
        .bus_gnt(bus_gnt), .valid_vec(valid_vec), .dirty_vec(dirty_vec),
        .bus_req(req_i), .wb_line(line_i), .clr_en(clr_en), .clr_idx(clr_idx),
        .inval_all(inval_all), .flush_ack(ack_i), .busy(busy)
    );

    cfs_irq_latch u_irq (
        .clk(clk), .rst_n(rst_n), .en(en), .req(req_vec), .busy(busy),
        .stop_grant(stop_grant), .start(start),
        .irq_valid(irqv_i), .irq_id(id_i)
    );

    assert_float_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        float_test |=> float_test);
    assert_float_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        float_test |-> (!bus_req && !flush_busy && !irq_valid && !flush_ack));
endmodule

// File: tb/sim_cflush_seq.sv
module sim_cflush_seq;
    localparam int L = 8;
    localparam int W = 3;
    localparam int IW = $clog2(L);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush_req = 0, smi_req = 0, init_req = 0, nmi_req = 0;
    logic stop_grant = 0, bus_boff = 0, bus_ahold = 0, bus_hlda = 0;
    logic bus_gnt = 1;
    logic fill_en = 0, fill_dirty = 0;
    logic [IW-1:0] fill_idx = '0, probe_idx = '0;
    logic bus_req, flush_ack, flush_busy, irq_valid, probe_valid, probe_dirty;
    logic bus_oe, float_test;
    logic [IW-1:0] wb_line;
    logic [1:0] irq_id;

    always #4 clk = ~clk;

    cflush_seq #(.LINES(L), .WB_CYCLES(W)) u0 (
        .clk(clk), .rst_n(rst_n), .flush_req(flush_req), .smi_req(smi_req),
        .init_req(init_req), .nmi_req(nmi_req), .stop_grant(stop_grant),
        .bus_boff(bus_boff), .bus_ahold(bus_ahold), .bus_hlda(bus_hlda),
        .bus_gnt(bus_gnt), .fill_en(fill_en), .fill_idx(fill_idx),
        .fill_dirty(fill_dirty), .probe_idx(probe_idx), .bus_req(bus_req),
        .wb_line(wb_line), .flush_ack(flush_ack), .flush_busy(flush_busy),
        .irq_valid(irq_valid), .irq_id(irq_id), .probe_valid(probe_valid),
        .probe_dirty(probe_dirty), .bus_oe(bus_oe), .float_test(float_test)
    );

    int total = 0, bad = 0, cyc = 0;
    int att_cnt = 0, busy_cnt = 0, ack_cnt = 0, irq_cnt = 0, irq_bad = 0;
    int att_line [0:15];
    int irq_log [0:7];
    int irq_cyc [0:7];
    logic req_prev = 0;
    bit wd_fired = 0;

    // Monitor: samples outputs on the falling edge.
    always @(negedge clk) begin
        cyc++;
        if (bus_req && !req_prev) begin
            if (att_cnt < 16) att_line[att_cnt] = int'(wb_line);
            att_cnt++;
        end
        req_prev = bus_req;
        if (flush_busy) busy_cnt++;
        if (flush_ack) ack_cnt++;
        if (irq_valid) begin
            if (irq_cnt < 8) begin
                irq_log[irq_cnt] = int'(irq_id);
                irq_cyc[irq_cnt] = cyc;
            end
            irq_cnt++;
            if (flush_busy) irq_bad++;
        end
        if (cyc > 150000 && !wd_fired) begin
            wd_fired = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        att_cnt = 0; busy_cnt = 0; ack_cnt = 0; irq_cnt = 0; irq_bad = 0;
    endtask

    task automatic do_reset(input logic fl);
        rst_n = 0;
        flush_req = fl;
        tick(3);
        rst_n = 1;
        flush_req = 0;
        tick(2);
    endtask

    // Load every line valid, dirty where the pattern bit is set.
    task automatic fill_all(input int pat);
        for (int i = 0; i < L; i++) begin
            fill_en = 1;
            fill_idx = IW'(i);
            fill_dirty = pat[i];
            tick(1);
        end
        fill_en = 0;
        tick(1);
    endtask

    task automatic scan_table(output int nv, output int nd);
        nv = 0;
        nd = 0;
        for (int i = 0; i < L; i++) begin
            probe_idx = IW'(i);
            #1;
            nv += int'(probe_valid);
            nd += int'(probe_dirty);
        end
    endtask

    task automatic pulse_flush();
        flush_req = 1;
        tick(1);
        flush_req = 0;
    endtask

    task automatic wait_ack(input int n);
        for (int i = 0; i < 800 && ack_cnt < n; i++) tick(1);
        tick(2);
    endtask

    initial begin
        int nv, nd, pop, exp_busy, order_bad, k;
        do_reset(0);

        // R11: reset state
        chk("R11 busy after reset", int'(flush_busy), 0);
        chk("R11 bus_req after reset", int'(bus_req), 0);
        chk("R11 bus_oe after reset", int'(bus_oe), 1);
        chk("R11 float after reset", int'(float_test), 0);
        scan_table(nv, nd);
        chk("R11 valid lines after reset", nv, 0);

        // R2/R3: sweep every dirty pattern
        for (int p = 0; p < (1 << L); p++) begin
            fill_all(p);
            clear_counts();
            pulse_flush();
            wait_ack(1);
            pop = $countones(p[L-1:0]);
            exp_busy = L + pop * (W + 1) + 3;
            chk($sformatf("R2 writebacks pattern %0d", p), att_cnt, pop);
            chk($sformatf("R3 busy cycles pattern %0d", p), busy_cnt, exp_busy);
            chk($sformatf("R3 ack count pattern %0d", p), ack_cnt, 1);
            order_bad = 0;
            k = 0;
            for (int i = 0; i < L; i++) begin
                if (p[i]) begin
                    if (k < 16 && att_line[k] != i) order_bad++;
                    k++;
                end
            end
            chk($sformatf("R2 writeback order pattern %0d", p), order_bad, 0);
            scan_table(nv, nd);
            chk($sformatf("R2 table cleared pattern %0d", p), nv + nd, 0);
        end

        // R1: level held high gives one flush
        fill_all(0);
        clear_counts();
        flush_req = 1;
        tick(200);
        flush_req = 0;
        tick(2);
        chk("R1 one flush for held level", ack_cnt, 1);

        // R4: backoff in mid-transfer of line 1
        fill_all(8'h22);
        clear_counts();
        pulse_flush();
        for (int i = 0; i < 100 && !bus_req; i++) tick(1);
        tick(2);
        bus_boff = 1;
        tick(3);
        bus_boff = 0;
        wait_ack(1);
        chk("R4 attempts with one abort", att_cnt, 3);
        chk("R4 first attempt line", att_line[0], 1);
        chk("R4 retry same line", att_line[1], 1);
        chk("R4 next line not repeated", att_line[2], 5);
        chk("R4 ack after abort", ack_cnt, 1);

        // R5: bus held, nothing dirty
        fill_all(0);
        clear_counts();
        bus_ahold = 1;
        pulse_flush();
        tick(40);
        scan_table(nv, nd);
        chk("R5 invalidated while held", nv, 0);
        chk("R5 ack waits for bus", ack_cnt, 0);
        chk("R5 still busy", int'(flush_busy), 1);
        bus_ahold = 0;
        wait_ack(1);
        chk("R5 ack after release", ack_cnt, 1);

        // R6: bus held, line 3 dirty
        fill_all(8'h08);
        clear_counts();
        bus_hlda = 1;
        pulse_flush();
        tick(40);
        scan_table(nv, nd);
        chk("R6 no request while held", att_cnt, 0);
        chk("R6 no line invalidated", nv, L);
        chk("R6 dirty line kept", nd, 1);
        chk("R6 no ack while held", ack_cnt, 0);
        bus_hlda = 0;
        wait_ack(1);
        scan_table(nv, nd);
        chk("R6 writeback after release", att_cnt, 1);
        chk("R6 table cleared after release", nv + nd, 0);

        // R7: stop-grant defers the flush
        fill_all(0);
        clear_counts();
        stop_grant = 1;
        pulse_flush();
        tick(30);
        chk("R7 no flush in stop-grant", busy_cnt, 0);
        stop_grant = 0;
        wait_ack(1);
        chk("R7 flush after stop-grant exit", ack_cnt, 1);

        // R8/R9: interrupts during a flush
        fill_all(8'hFF);
        clear_counts();
        pulse_flush();
        tick(5);
        smi_req = 1; tick(1); smi_req = 0;
        flush_req = 1; tick(1); flush_req = 0;
        nmi_req = 1; tick(1); nmi_req = 0;
        init_req = 1; tick(1); init_req = 0;
        wait_ack(1);
        tick(4);
        chk("R8 no irq while busy", irq_bad, 0);
        chk("R9 irq count", irq_cnt, 4);
        chk("R9 first is NMI", irq_log[0], 0);
        chk("R9 second is INIT", irq_log[1], 1);
        chk("R9 third is SMI", irq_log[2], 2);
        chk("R9 fourth is FLUSH", irq_log[3], 3);
        chk("R9 one per cycle", irq_cyc[3] - irq_cyc[0], 3);
        wait_ack(2);
        chk("R9 latched flush runs", ack_cnt, 2);

        // R10: float-test mode
        do_reset(1);
        chk("R10 float entered", int'(float_test), 1);
        chk("R10 bus_oe low", int'(bus_oe), 0);
        clear_counts();
        pulse_flush();
        tick(30);
        chk("R10 flush ignored", busy_cnt + ack_cnt, 0);
        do_reset(0);
        chk("R10 float left on reset", int'(float_test), 0);
        chk("R10 bus_oe restored", int'(bus_oe), 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule